// File: doc/BRIEF.md
# Colour Lookup Table with Posted Write Queue

This block is a 256-entry colour lookup table that software fills through a small queue of posted writes. The bus side hands the block an index, a 32-bit colour word and a target select (palette or gamma). If a queue slot is free, the write is accepted at once. A free-slot counter is always readable, so a driver can poll it and wait while it reads zero. Queued writes move into the tables in the background, one per clock. This happens only while a programmable horizontal or vertical colormap window is open. Those windows are normally set to match the blanking intervals, so the tables are never changed while the display is reading them.

On the pixel side, an 8-bit index returns a 24-bit colour from the palette one clock later. A second table of the same shape holds gamma values and has its own lookup port. The gamma table starts out as an identity ramp after reset. Both tables share the one write queue, and writes retire in the order they were accepted.

Top module: `clut_palette_fifo`

## Requirements
- R1: The tables hold 256 entries. A write whose 9-bit index is 256 or more is discarded: it uses no slot, does not set the overflow flag and changes no entry.
- R2: A colour word carries red in bits 31:24, green in bits 23:16 and blue in bits 15:8. Bits 7:0 are ignored. The looked-up colour is {red, green, blue}, with red in bits 23:16 and blue in bits 7:0.
- R3: `free_slots` reads 8 after reset. It drops by one in the cycle after each accepted write, and rises by one in the cycle after each entry leaves the queue.
- R4: A write with a valid index that arrives while `free_slots` is 0 is discarded. It sets `overflow`, which stays set until reset. `overflow` is 0 after reset.
- R5: At most one entry leaves the queue per clock. This happens only when hpos lies in [h_win_on, h_win_off) or vpos lies in [v_win_on, v_win_off). Entries retire in acceptance order, across both tables.
- R6: `pix_colour` shows the palette entry addressed by `pix_index` one clock after the index is presented. When a drain writes the same entry in that same clock, the old value is returned.
- R7: `wr_gamma`=1 sends a write to the gamma table. After reset, gamma entry i holds {i, i, i}. `gam_colour` shows the gamma entry addressed by `gam_index` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A table write is offered this cycle |
| wr_gamma | input | 1 | 1 targets the gamma table, 0 the palette |
| wr_index | input | 9 | Entry index; 256 and above are rejected |
| wr_word | input | 32 | Colour word, R/G/B in bits 31:8 |
| free_slots | output | 4 | Number of free queue slots |
| overflow | output | 1 | Sticky flag for a write lost to a full queue |
| hpos | input | 12 | Current horizontal position |
| vpos | input | 12 | Current vertical position |
| h_win_on | input | 12 | First horizontal position of the drain window |
| h_win_off | input | 12 | Horizontal position that ends the drain window |
| v_win_on | input | 12 | First vertical position of the drain window |
| v_win_off | input | 12 | Vertical position that ends the drain window |
| pix_index | input | 8 | Palette lookup index |
| pix_colour | output | 24 | Palette colour, one clock after the index |
| gam_index | input | 8 | Gamma lookup index |
| gam_colour | output | 24 | Gamma value, one clock after the index |

## Verification
The bench builds the block with its default parameters: a queue depth of 8, 256 entries and 12-bit positions. At depth 8, a burst of ten writes with the window shut reaches both the full-queue drop and the sticky overflow flag within a few cycles. The default 256-entry size also lets the bench offer 9-bit indices just above the table and see them rejected. Positions are held to small values, so both drain windows open and close many times during a few hundred cycles of mixed traffic. This includes drains that hit the entry being looked up in the same clock.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef logic [23:0] rgb_t;

  // Pull the colour channels out of a bus word (R 31:24, G 23:16, B 15:8).
  function automatic rgb_t word_to_rgb(input logic [31:0] w);
    return w[31:8];
  endfunction

  // Half-open window test: open when on <= pos < off.
  function automatic logic pos_in_window(input logic [15:0] pos,
                                         input logic [15:0] on_pos,
                                         input logic [15:0] off_pos);
    return (pos >= on_pos) && (pos < off_pos);
  endfunction

  // Identity ramp value for a gamma entry.
  function automatic rgb_t ramp_value(input int unsigned i);
    logic [7:0] v;
    v = i[7:0];
    return {v, v, v};
  endfunction

endpackage

// File: rtl/clut_post_fifo.sv
module clut_post_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 33,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign dout  = slot_q[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_ptr] <= din;
  end

  // R3: occupancy never exceeds the depth
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R4: the caller never pushes into a full queue
  a_r4_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R5: the drain never pops an empty queue
  a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);

endmodule

// File: rtl/clut_table.sv
module clut_table #(
  parameter int ENTRIES  = 256,
  parameter int IDX_W    = 8,
  parameter bit IDENTITY = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  clut_pkg::rgb_t   wdata,
  input  logic [IDX_W-1:0] raddr,
  output clut_pkg::rgb_t   rdata
);

  clut_pkg::rgb_t cell_q [ENTRIES];

  generate
    if (IDENTITY) begin : g_ramp_init
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < ENTRIES; i++) cell_q[i] <= clut_pkg::ramp_value(i);
        end else if (we) begin
          cell_q[waddr] <= wdata;
        end
      end
    end else begin : g_zero_init
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < ENTRIES; i++) cell_q[i] <= '0;
        end else if (we) begin
          cell_q[waddr] <= wdata;
        end
      end
    end
  endgenerate

  // Registered read: the old contents are seen when a write hits the same cell.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= cell_q[raddr];
  end

endmodule

// File: rtl/clut_palette_fifo.sv
module clut_palette_fifo #(
  parameter int DEPTH   = 8,
  parameter int ENTRIES = 256,
  parameter int POS_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_gamma,
  input  logic [IDX_W:0]   wr_index,
  input  logic [31:0]      wr_word,
  output logic [CNT_W-1:0] free_slots,
  output logic             overflow,
  input  logic [POS_W-1:0] hpos,
  input  logic [POS_W-1:0] vpos,
  input  logic [POS_W-1:0] h_win_on,
  input  logic [POS_W-1:0] h_win_off,
  input  logic [POS_W-1:0] v_win_on,
  input  logic [POS_W-1:0] v_win_off,
  input  logic [IDX_W-1:0] pix_index,
  output logic [23:0]      pix_colour,
  input  logic [IDX_W-1:0] gam_index,
  output logic [23:0]      gam_colour
);

  typedef struct packed {
    logic             to_gamma;
    logic [IDX_W-1:0] idx;
    clut_pkg::rgb_t   rgb;
  } post_t;

  localparam int ENT_W = $bits(post_t);

  // Named internal events used by the assertions.
  logic             index_ok, q_full, q_empty, win_open;
  logic             push_ev, drop_ev, drain_ev;
  logic [CNT_W-1:0] q_count;
  post_t            in_ent, out_ent;

  assign index_ok = (wr_index < (IDX_W + 1)'(ENTRIES));
  assign push_ev  = wr_valid && index_ok && !q_full;
  assign drop_ev  = wr_valid && index_ok && q_full;
  assign win_open = clut_pkg::pos_in_window(16'(hpos), 16'(h_win_on), 16'(h_win_off)) ||
                    clut_pkg::pos_in_window(16'(vpos), 16'(v_win_on), 16'(v_win_off));
  assign drain_ev = win_open && !q_empty;

  assign in_ent.to_gamma = wr_gamma;
  assign in_ent.idx      = wr_index[IDX_W-1:0];
  assign in_ent.rgb      = clut_pkg::word_to_rgb(wr_word);

  clut_post_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_ev),
    .din   (in_ent),
    .pop   (drain_ev),
    .dout  (out_ent),
    .count (q_count),
    .full  (q_full),
    .empty (q_empty)
  );

  assign free_slots = CNT_W'(DEPTH) - q_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overflow <= 1'b0;
    else if (drop_ev) overflow <= 1'b1;
  end

  clut_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .IDENTITY(1'b0)) u_palette (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (drain_ev && !out_ent.to_gamma),
    .waddr (out_ent.idx),
    .wdata (out_ent.rgb),
    .raddr (pix_index),
    .rdata (pix_colour)
  );

  clut_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .IDENTITY(1'b1)) u_gamma (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (drain_ev && out_ent.to_gamma),
    .waddr (out_ent.idx),
    .wdata (out_ent.rgb),
    .raddr (gam_index),
    .rdata (gam_colour)
  );

  // R1: an out-of-range write never takes a slot
  a_r1_reject_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !index_ok) |=> (free_slots >= $past(free_slots)));
  // R3: an accepted write without a drain costs exactly one slot
  a_r3_slot_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ev && !drain_ev) |=> (free_slots == $past(free_slots) - 1'b1));
  // R4: overflow is raised by a write that finds no slot, then holds
  a_r4_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && index_ok && free_slots == '0) |=> overflow);
  a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R5: with both windows shut, no slot is given back
  a_r5_closed_no_drain: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> (free_slots <= $past(free_slots)));

endmodule

// File: tb/clut_palette_fifo_test.sv
module clut_palette_fifo_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_gamma = 1'b0;
  logic [8:0]  wr_index = '0;
  logic [31:0] wr_word = '0;
  logic [3:0]  free_slots;
  logic        overflow;
  logic [11:0] hpos = '0, vpos = '0;
  logic [11:0] h_win_on = 12'd10, h_win_off = 12'd20;
  logic [11:0] v_win_on = 12'd100, v_win_off = 12'd110;
  logic [7:0]  pix_index = '0, gam_index = '0;
  logic [23:0] pix_colour, gam_colour;

  int checks = 0, fails = 0, cycles = 0;
  string phase = "reset";

  clut_palette_fifo uut (.*);

  always #4 clk = ~clk;   // 125 MHz

  // Behavioural reference model
  logic [32:0] q[$];
  logic [23:0] pal_m [256];
  logic [23:0] gam_m [256];
  logic        ovf_m;
  logic [23:0] exp_pix, exp_gam;

  task automatic model_reset();
    q.delete();
    for (int i = 0; i < 256; i++) begin
      pal_m[i] = '0;
      gam_m[i] = {i[7:0], i[7:0], i[7:0]};
    end
    ovf_m = 1'b0; exp_pix = '0; exp_gam = '0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    logic [32:0] e;
    bit take, open;
    if (!rst_n) model_reset();
    else begin
      open = (hpos >= h_win_on && hpos < h_win_off) || (vpos >= v_win_on && vpos < v_win_off);
      exp_pix = pal_m[pix_index];
      exp_gam = gam_m[gam_index];
      take = 0;
      if (wr_valid && wr_index < 9'd256) begin
        if (q.size() == 8) ovf_m = 1'b1;
        else take = 1;
      end
      if (open && q.size() > 0) begin
        e = q.pop_front();
        if (e[32]) gam_m[e[31:24]] = e[23:0];
        else       pal_m[e[31:24]] = e[23:0];
      end
      if (take) q.push_back({wr_gamma, wr_index[7:0], wr_word[31:24], wr_word[23:16], wr_word[15:8]});
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) t=%0t actual=%h expected=%h", tag, phase, $time, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 free_slots", 32'(free_slots), 32'(8 - q.size()));
      check("R4 overflow", 32'(overflow), 32'(ovf_m));
      check("R2 R6 pix_colour", 32'(pix_colour), 32'(exp_pix));
      check("R7 gam_colour", 32'(gam_colour), 32'(exp_gam));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic put(bit g, int idx, logic [31:0] w);
    wr_valid = 1'b1; wr_gamma = g; wr_index = 9'(idx); wr_word = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    // Reset state: R3 free count 8, R4 overflow low
    idle(2);
    checks++; if (free_slots !== 4'd8) begin fails++; $display("FAIL R3 reset free actual=%0d expected=8", free_slots); end
    checks++; if (overflow !== 1'b0) begin fails++; $display("FAIL R4 reset overflow actual=%0b expected=0", overflow); end
    rst_n = 1'b1;
    idle(1);

    // R3 R5: writes held while both windows shut; R2 low byte ignored
    phase = "R5 closed";
    hpos = 12'd0; vpos = 12'd0;
    put(0, 5, 32'h11223344);
    put(0, 6, 32'hA0B0C0FF);
    put(1, 7, 32'h01020304);
    idle(3);
    // R1: index 300 rejected, no slot used
    phase = "R1 out of range";
    put(0, 300, 32'hDEADBEEF);
    idle(2);
    // R5: open horizontal window, queue drains one per clock
    phase = "R5 hwin drain";
    hpos = 12'd12; pix_index = 8'd5; gam_index = 8'd7;
    idle(5);
    hpos = 12'd20;  // off position is outside
    pix_index = 8'd6; idle(2);
    pix_index = 8'd44; idle(2);  // R1: 300 mod 256 untouched

    // R4: ten writes into a shut window, two dropped
    phase = "R4 overflow";
    hpos = 12'd0;
    for (int i = 0; i < 10; i++) put(0, 20 + i, {8'(i), 8'(i * 3), 8'(255 - i), 8'h00});
    idle(2);
    // R6: drain via vertical window while looking up the entry being written
    phase = "R6 same index";
    vpos = 12'd100; pix_index = 8'd20;
    idle(1); pix_index = 8'd21; idle(1); pix_index = 8'd22; idle(8);
    vpos = 12'd0;

    // R7: identity gamma and gamma writes
    phase = "R7 gamma";
    for (int i = 0; i < 4; i++) begin gam_index = 8'(i * 60); idle(1); end
    put(1, 200, 32'h55667788);
    hpos = 12'd15; gam_index = 8'd200; idle(4); hpos = 12'd0;

    // Mixed traffic across both windows
    phase = "mixed";
    for (int c = 0; c < 400; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr_valid = lfsr[0] | lfsr[1];
      wr_gamma = lfsr[2];
      wr_index = {lfsr[3] & lfsr[4] & lfsr[5], lfsr[13:6]};
      wr_word = {lfsr, lfsr[7:0], lfsr[15:8]};
      hpos = 12'(lfsr[12:8] + 5'd3);
      vpos = lfsr[15] ? 12'd105 : 12'd0;
      pix_index = {3'b000, lfsr[9:5]};
      gam_index = {3'b000, lfsr[14:10]};
      idle(1);
    end
    wr_valid = 1'b0; hpos = 12'd12; idle(12);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule